// File: doc/BRIEF.md
# Shared-Exponent Stochastic Requantizer

This block takes a stream of wide signed accumulator words and turns each one into a narrow signed code X. The code stands for the real value X·2^−f, and every element of a group shares the same fractional-bit count f, such as all the weights of one layer. Each input word is read as a fixed-point number with `FRAC_IN` fractional bits. The block drops the bits below the current f and rounds stochastically. It then saturates the result to the code range. Alongside the data path it keeps statistics for the group window that is open.

When the element marked as last in its group is accepted, the block picks the exponent for the next window. If too many values overflowed, f moves down by one, which gives more integer range. If no value reached the upper half of the code range, f moves up by one, which gives more resolution. The result is held between programmable limits. The random bits for rounding come from a 16-bit LFSR that steps once for every accepted element.

Top module: `dfx_requant`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. `out_code` and `out_frac` belong to that accepted element, and `out_frac` is the f that was used to quantize it.
- R2: Let s = `FRAC_IN` − f. The unclipped value is floor(A / 2^s) + u, where A is the signed input. The term u is 1 when the low s bits of the random word are less than the low s bits of A, and 0 otherwise. An input of zero gives code zero.
- R3: The random word is the LFSR state before it advances. The LFSR has seed 0xACE1, next state {q[14:0], q[15]^q[13]^q[12]^q[10]}, steps once per accepted element, and is never zero.
- R4: An unclipped value above 2^(CODE_W−1)−1 gives the code 2^(CODE_W−1)−1. One below −2^(CODE_W−1) gives −2^(CODE_W−1). Either case counts as one overflow.
- R5: The window overflow count saturates at 2^CNT_W−1 and clears when a window closes.
- R6: On the last element, if the overflow count including that element is greater than `cfg_ovf_limit`, the candidate f is f−1.
- R7: On the last element, if R6 does not apply and no unclipped value in the window was ≥ 2^(CODE_W−2) or < −2^(CODE_W−2), the candidate f is f+1. A value of exactly −2^(CODE_W−2) does not count as a high value.
- R8: On the last element, if neither R6 nor R7 applies, f is unchanged. Between window closes, `cur_frac` holds its value.
- R9: The candidate f is clamped to [`cfg_frac_min`, `cfg_frac_max`]. Configuration must keep min ≤ max ≤ `FRAC_IN`.
- R10: The new f shows on `cur_frac` one cycle after the last element is accepted. It applies from the next accepted element on.
- R11: While reset is asserted, `out_valid` is 0 and `cur_frac` equals `F_RESET`. Reset also clears the window statistics and reloads the LFSR seed.
- R12: For inputs whose discarded fraction is exactly one half, about half of the results round up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present; always accepted |
| in_data | input | ACC_W | Signed accumulator word, FRAC_IN fractional bits |
| in_last | input | 1 | Marks the final element of the group window |
| cfg_ovf_limit | input | CNT_W | f is lowered when the overflow count exceeds this |
| cfg_frac_min | input | FW | Lower clamp on f |
| cfg_frac_max | input | FW | Upper clamp on f |
| out_valid | output | 1 | Output code present |
| out_code | output | CODE_W | Signed narrow code |
| out_frac | output | FW | f used for this code |
| cur_frac | output | FW | f currently in force |

## Verification
Each code appears on the outputs one cycle after its input is accepted. An updated exponent appears on `cur_frac` one cycle after the last element is accepted. The bench drives each input at a falling edge and samples at the next falling edge, so the code, its `out_frac` and the new `cur_frac` are all read half a period after the edge that registered them. Expected codes come from a bench-side model of the rounding rule and of the stated LFSR sequence, stepped once for every element driven. The same model tracks the exponent decisions.

// File: rtl/dfx_pkg.sv
package dfx_pkg;
  localparam int RND_W = 16;
  localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

  typedef struct packed {
    logic ovf;
    logic hi;
  } dfx_flag_t;

  function automatic logic [RND_W-1:0] lfsr_step(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/dfx_rst_sync.sv
module dfx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dfx_lfsr.sv
module dfx_lfsr
  import dfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [RND_W-1:0] state
);
  logic [RND_W-1:0] state_q, state_d;

  always_comb begin
    state_d = lfsr_step(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= RND_SEED;
    else if (adv) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/dfx_round_clip.sv
module dfx_round_clip
  import dfx_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int FRAC_IN = 16,
  parameter int CODE_W  = 12,
  parameter int FW      = 5
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [FW-1:0]     frac,
  input  logic [RND_W-1:0]  rnd,
  output logic [CODE_W-1:0] code,
  output dfx_flag_t         flags
);
  localparam int SW = $clog2(FRAC_IN + 1);
  localparam logic signed [ACC_W:0] CMAX  = (ACC_W+1)'(2**(CODE_W-1) - 1);
  localparam logic signed [ACC_W:0] CMIN  = (ACC_W+1)'(-(2**(CODE_W-1)));
  localparam logic signed [ACC_W:0] HALFP = (ACC_W+1)'(2**(CODE_W-2));
  localparam logic signed [ACC_W:0] HALFN = (ACC_W+1)'(-(2**(CODE_W-2)));

  logic [SW-1:0]           sh;
  logic signed [ACC_W:0]   ext, floor_v, rounded;
  logic [ACC_W-1:0]        mask, dropped, thr, rnd_ext;
  logic                    up;

  always_comb begin
    if (frac >= FW'(FRAC_IN)) sh = '0;
    else                      sh = SW'(FRAC_IN) - SW'(frac);
    ext     = $signed({acc[ACC_W-1], acc});
    floor_v = ext >>> sh;
    mask    = (ACC_W'(1) << sh) - ACC_W'(1);
    rnd_ext = {{(ACC_W-RND_W){1'b0}}, rnd};
    dropped = acc & mask;
    thr     = rnd_ext & mask;
    up      = thr < dropped;
    rounded = floor_v + $signed({{ACC_W{1'b0}}, up});
    flags.ovf = (rounded > CMAX) || (rounded < CMIN);
    flags.hi  = (rounded >= HALFP) || (rounded < HALFN);
    if (rounded > CMAX)      code = CMAX[CODE_W-1:0];
    else if (rounded < CMIN) code = CMIN[CODE_W-1:0];
    else                     code = rounded[CODE_W-1:0];
  end
endmodule

// File: rtl/dfx_scale_ctrl.sv
module dfx_scale_ctrl
  import dfx_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int FW      = 5,
  parameter int F_RESET = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             last,
  input  dfx_flag_t        flags,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic [FW-1:0]    cfg_min,
  input  logic [FW-1:0]    cfg_max,
  output logic [FW-1:0]    frac
);
  logic [CNT_W-1:0]       cnt_q, cnt_d, cnt_sat;
  logic [CNT_W:0]         sum;
  logic                   hi_q, hi_d, hi_any;
  logic [FW-1:0]          frac_q, frac_new;
  logic signed [FW+1:0]   cand, lo_s, hi_s;

  always_comb begin
    sum     = {1'b0, cnt_q} + (CNT_W+1)'(flags.ovf);
    cnt_sat = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    hi_any  = hi_q | flags.hi;
    cand    = $signed({2'b00, frac_q});
    if (cnt_sat > cfg_limit) cand = cand - $signed((FW+2)'(1));
    else if (!hi_any)        cand = cand + $signed((FW+2)'(1));
    lo_s = $signed({2'b00, cfg_min});
    hi_s = $signed({2'b00, cfg_max});
    if (cand < lo_s)      frac_new = cfg_min;
    else if (cand > hi_s) frac_new = cfg_max;
    else                  frac_new = cand[FW-1:0];
    cnt_d = last ? '0 : cnt_sat;
    hi_d  = last ? 1'b0 : hi_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hi_q   <= 1'b0;
      frac_q <= FW'(F_RESET);
    end else if (accept) begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      if (last) frac_q <= frac_new;
    end
  end

  assign frac = frac_q;
endmodule

// File: rtl/dfx_requant.sv
module dfx_requant
  import dfx_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int FRAC_IN = 16,
  parameter int CODE_W  = 12,
  parameter int CNT_W   = 6,
  parameter int FW      = 5,
  parameter int F_RESET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ACC_W-1:0]  in_data,
  input  logic              in_last,
  input  logic [CNT_W-1:0]  cfg_ovf_limit,
  input  logic [FW-1:0]     cfg_frac_min,
  input  logic [FW-1:0]     cfg_frac_max,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic [FW-1:0]     out_frac,
  output logic [FW-1:0]     cur_frac
);
  logic              rst_sync_n;
  logic [RND_W-1:0]  rnd_w;
  logic [CODE_W-1:0] code_w;
  logic [FW-1:0]     frac_w;
  dfx_flag_t         flags_w;
  logic              valid_q;
  logic [CODE_W-1:0] code_q;
  logic [FW-1:0]     ofrac_q;

  dfx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  dfx_lfsr u_lfsr (.clk(clk), .rst_n(rst_sync_n), .adv(in_valid), .state(rnd_w));

  dfx_round_clip #(.ACC_W(ACC_W), .FRAC_IN(FRAC_IN), .CODE_W(CODE_W), .FW(FW)) u_rc (
    .acc(in_data), .frac(frac_w), .rnd(rnd_w), .code(code_w), .flags(flags_w)
  );

  dfx_scale_ctrl #(.CNT_W(CNT_W), .FW(FW), .F_RESET(F_RESET)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .accept(in_valid), .last(in_last), .flags(flags_w),
    .cfg_limit(cfg_ovf_limit), .cfg_min(cfg_frac_min), .cfg_max(cfg_frac_max), .frac(frac_w)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q  <= '0;
      ofrac_q <= '0;
    end else if (in_valid) begin
      code_q  <= code_w;
      ofrac_q <= frac_w;
    end
  end

  assign out_valid = valid_q;
  assign out_code  = code_q;
  assign out_frac  = ofrac_q;
  assign cur_frac  = frac_w;
endmodule

// File: rtl/dfx_requant_chk.sv
module dfx_requant_chk #(
  parameter int ACC_W  = 24,
  parameter int CODE_W = 12,
  parameter int FW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_last,
  input logic [ACC_W-1:0]  in_data,
  input logic [FW-1:0]     cfg_min,
  input logic [FW-1:0]     cfg_max,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic [FW-1:0]     out_frac,
  input logic [FW-1:0]     cur_frac,
  input logic [15:0]       rnd
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_FRAC_TAGGED: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_frac == $past(cur_frac)); // R10
  AST_FRAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(in_valid && in_last) |=> $stable(cur_frac)); // R8
  AST_FRAC_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_last) |=> (cur_frac >= cfg_min && cur_frac <= cfg_max)); // R9
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_data == '0) |=> out_code == '0); // R2
  AST_RND_LIVE: assert property (@(posedge clk) disable iff (!rst_n) rnd != 16'h0000); // R3
endmodule

bind dfx_requant dfx_requant_chk #(.ACC_W(ACC_W), .CODE_W(CODE_W), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_last(in_last), .in_data(in_data),
  .cfg_min(cfg_frac_min), .cfg_max(cfg_frac_max), .out_valid(out_valid), .out_code(out_code),
  .out_frac(out_frac), .cur_frac(cur_frac), .rnd(rnd_w)
);

// File: tb/dfx_requant_tb.sv
`timescale 1ns/1ps
module dfx_requant_tb;
  localparam int ACC_W = 24, CODE_W = 12, CNT_W = 6, FW = 5, FRAC_IN = 16, F_RESET = 8;
  localparam int NROW = 12;
  localparam int TBL_D[NROW] = '{25637, -51400, 2047, 384000, -640000, 704,
                                 384000, 769, 1024000, -262144, -131200, 131072};
  localparam bit TBL_L[NROW] = '{0, 0, 1, 0, 0, 1, 0, 1, 1, 1, 1, 1};
  localparam int TBL_F[NROW] = '{8, 8, 8, 9, 9, 9, 8, 8, 8, 8, 9, 9};

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_last = 0;
  logic [ACC_W-1:0] in_data = '0;
  logic [CNT_W-1:0] cfg_ovf_limit = 6'd1;
  logic [FW-1:0] cfg_frac_min = 5'd4, cfg_frac_max = 5'd10;
  logic out_valid;
  logic [CODE_W-1:0] out_code;
  logic [FW-1:0] out_frac, cur_frac;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] m_lfsr;
  int m_f, m_cnt, m_lim, m_min, m_max;
  bit m_hi;

  always #4 clk = ~clk;

  dfx_requant #(.ACC_W(ACC_W), .FRAC_IN(FRAC_IN), .CODE_W(CODE_W), .CNT_W(CNT_W),
                .FW(FW), .F_RESET(F_RESET)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .cfg_ovf_limit(cfg_ovf_limit), .cfg_frac_min(cfg_frac_min), .cfg_frac_max(cfg_frac_max),
    .out_valid(out_valid), .out_code(out_code), .out_frac(out_frac), .cur_frac(cur_frac)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lfsr = 16'hACE1; m_f = F_RESET; m_cnt = 0; m_hi = 0;
  endtask

  task automatic model_step(input int a, input bit last, output int code);
    int s; longint al, fl, p, r, rv; bit ovf, hi;
    s  = (m_f >= FRAC_IN) ? 0 : FRAC_IN - m_f;
    al = a;
    fl = al >>> s;
    p  = al & ((64'sd1 <<< s) - 1);
    r  = longint'(m_lfsr) & ((64'sd1 <<< s) - 1);
    rv = fl + ((r < p) ? 1 : 0);
    ovf = (rv > 2047) || (rv < -2048);
    hi  = (rv >= 1024) || (rv < -1024);
    code = (rv > 2047) ? 2047 : (rv < -2048) ? -2048 : int'(rv);
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    m_cnt = (m_cnt + int'(ovf) > 63) ? 63 : m_cnt + int'(ovf);
    m_hi = m_hi | hi;
    if (last) begin
      if (m_cnt > m_lim) m_f = m_f - 1;
      else if (!m_hi)    m_f = m_f + 1;
      if (m_f < m_min) m_f = m_min;
      if (m_f > m_max) m_f = m_max;
      m_cnt = 0; m_hi = 0;
    end
  endtask

  task automatic set_cfg(input int lim, input int fmin, input int fmax);
    @(negedge clk);
    cfg_ovf_limit = CNT_W'(lim); cfg_frac_min = FW'(fmin); cfg_frac_max = FW'(fmax);
    m_lim = lim; m_min = fmin; m_max = fmax;
  endtask

  // Drives one element, then checks its code and f half a period after the registering edge.
  task automatic send(input int a, input bit last, input int exp_f, input string tag);
    int ec, pre_f;
    @(negedge clk);
    in_valid = 1; in_data = ACC_W'(a); in_last = last;
    pre_f = m_f;
    model_step(a, last, ec);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk(out_valid === 1'b1, "R1 valid", int'(out_valid), 1);
    chk(out_code === CODE_W'(ec), {"R2 R3 R4 code ", tag}, int'($signed(out_code)), ec);
    chk(out_frac === FW'(pre_f), {"R10 out_frac ", tag}, int'(out_frac), pre_f);
    if (exp_f >= 0) chk(pre_f == exp_f, {"R10 table f ", tag}, pre_f, exp_f);
    if (last) chk(cur_frac === FW'(m_f), {"R6 R7 R8 R9 cur_frac ", tag}, int'(cur_frac), m_f);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int ups;
    model_reset();
    m_lim = 1; m_min = 4; m_max = 10;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 valid in reset", int'(out_valid), 0);
    chk(cur_frac === FW'(F_RESET), "R11 f in reset", int'(cur_frac), F_RESET);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R1 idle", int'(out_valid), 0);

    // Table walk: windows covering increment, decrement, hold and the -1024 boundary.
    for (int i = 0; i < NROW; i++) send(TBL_D[i], TBL_L[i], TBL_F[i], $sformatf("row%0d", i));
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 drops after element", int'(out_valid), 0);
    chk(cur_frac === 5'd9, "R8 f after table", int'(cur_frac), 9);

    // R9: clamp at the upper bound.
    set_cfg(1, 4, 9);
    send(640, 1, 9, "fmax clamp R9");
    // R9: clamp at the lower bound.
    set_cfg(1, 9, 10);
    send(384000, 0, 9, "fmin a");
    send(384000, 0, 9, "fmin b");
    send(640, 1, 9, "fmin clamp R9");
    // R5: counter saturates at 63, 63 > 62 lowers f.
    set_cfg(62, 4, 10);
    for (int i = 0; i < 70; i++) send(384000, 0, 9, "sat");
    send(640, 1, 9, "sat close R5");
    chk(cur_frac === 5'd8, "R5 saturated count lowers f", int'(cur_frac), 8);

    // R12: half-way fractions at f=8 round up about half the time.
    ups = 0;
    for (int i = 0; i < 256; i++) begin
      send(2688, i == 255, 8, "half");
      if (out_code == 12'd11) ups++;
    end
    chk(ups >= 88 && ups <= 168, "R12 round-up share", ups, 128);

    // R11: reset mid-run.
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(out_valid === 1'b0, "R11 valid after reset", int'(out_valid), 0);
    chk(cur_frac === FW'(F_RESET), "R11 f after reset", int'(cur_frac), F_RESET);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    repeat (4) @(negedge clk);
    send(25637, 1, 8, "post-reset seed R3");
    finish_run();
  end
endmodule